// File: doc/BRIEF.md
# Multi-Line Receive Silo

This block merges received characters from several serial lines into one shared first-in first-out queue. Every per-line receiver reports a finished character with a one-cycle strobe, together with the character and its framing and parity status. The silo puts each accepted character into the queue with the number of its line and its error bits, so that the host can serve every line through one read register.

The host reads `rd_word`. When the valid bit is set, the word holds the oldest queued entry. Pulsing `rd_en` in that cycle removes the entry. The host keeps reading until the valid bit comes back clear. The receive-done output is high while anything is queued. The interrupt request is that same condition gated by the receive-interrupt enable.

Characters that cannot be stored are lost. The overrun bit records the loss on the entry that is stored next. A character is lost when it arrives while the queue is full, or when a line reports a new character before its previous one has entered the queue. No separate break indication exists: a break shows up as a framing error reported by the receiver.

Top module: `rx_silo`

## Requirements
- R1: `rd_word` packs one entry as follows: bit 13 valid, bit 12 overrun, bit 11 framing error, bit 10 parity error, bits 9:8 line number, bits 7:0 character. These positions apply with the default of four lines.
- R2: Entries are returned oldest first. A read (`rd_en` high while valid is set) removes exactly the entry shown.
- R3: A strobe is captured at one clock edge, and the entry becomes readable after the following edge. When several lines strobe in the same cycle, their entries are queued one per cycle, lowest line number first.
- R4: A strobe on a line whose `line_en` bit is low is ignored, and nothing is queued for it.
- R5: The framing and parity flags given with a strobe appear unchanged in that character's entry. A break appears only as a framing error.
- R6: The queue holds at most DEPTH (64) entries. A character that reaches the queue while it holds DEPTH entries is dropped, and the next entry written carries the overrun bit. Entries already queued are left unchanged.
- R7: If a line strobes again before its previous character has been queued, the previous character is lost. The new character is kept, and the next entry written carries the overrun bit.
- R8: `rx_done` is high exactly when the queue is not empty, which is also when the valid bit of `rd_word` is set.
- R9: `rx_irq` is high exactly when `rx_done` and `rie` are both high.
- R10: While the queue is empty, `rd_word` reads as all zeros, and a read changes nothing.
- R11: After reset the queue is empty, and `rx_done`, `rx_irq` and `rd_word` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | NUM_LINES | One-cycle strobe per line: character complete |
| rx_data | input | NUM_LINES*8 | Character per line, line i in bits 8i+7:8i |
| rx_ferr | input | NUM_LINES | Framing error (or break) with the strobe |
| rx_perr | input | NUM_LINES | Parity error with the strobe |
| line_en | input | NUM_LINES | Per-line receiver enable |
| rie | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Host read: remove the entry shown |
| rd_word | output | WORD_W | Valid bit plus head entry |
| rx_done | output | 1 | Queue not empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sweeps every strobe pattern and every enable pattern over the four lines and compares each drained word with a model queue. A picker that got the priority wrong would return simultaneous characters in the wrong line order. A missing enable gate would add extra entries. The queue is filled to exactly 64 entries and one more character is sent. A design without the full check would overwrite the oldest entry, and one without the sticky loss flag would return the next entry with its overrun bit clear. A line that strobes twice back to back must yield only its second character, flagged as an overrun. Empty reads must return zero and leave the queue untouched, and the done output must rise exactly two edges after a strobe.

// File: rtl/silo_pkg.sv
package silo_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rx_char_t;
endpackage

// File: rtl/silo_line_hold.sv
// One-character holding stage per line; waits for a grant from the picker.
module silo_line_hold
    import silo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              en,
    input  logic [CHAR_W-1:0] ch,
    input  logic              ferr,
    input  logic              perr,
    input  logic              grant,
    output logic              pend,
    output rx_char_t          data,
    output logic              clobber
);
    typedef struct packed {
        logic     pend;
        rx_char_t data;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        clobber = 1'b0;
        if (grant) begin
            s_d.pend = 1'b0;
        end
        if (stb && en) begin
            clobber       = s_q.pend && !grant;
            s_d.pend      = 1'b1;
            s_d.data.ferr = ferr;
            s_d.data.perr = perr;
            s_d.data.ch   = ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
    assign data = s_q.data;
endmodule

// File: rtl/silo_pick.sv
// Fixed-priority picker: lowest pending line number wins.
module silo_pick #(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req,
    output logic [NUM_LINES-1:0] grant,
    output logic [LINE_W-1:0]    idx,
    output logic                 any
);
    always_comb begin
        idx   = '0;
        grant = '0;
        any   = |req;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = LINE_W'(i);
            end
        end
        if (any) begin
            grant[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/silo_fifo.sv
// Circular entry store with occupancy count.
module silo_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 64,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[s_q.wr] <= wdata;
        end
    end

    assign rdata = mem[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/rx_silo.sv
// Shared multi-line receive queue with tagged entries.
module rx_silo
    import silo_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 64,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    parameter int ENTRY_W   = 3 + LINE_W + CHAR_W,
    parameter int WORD_W    = ENTRY_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        rx_stb,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_data,
    input  logic [NUM_LINES-1:0]        rx_ferr,
    input  logic [NUM_LINES-1:0]        rx_perr,
    input  logic [NUM_LINES-1:0]        line_en,
    input  logic                        rie,
    input  logic                        rd_en,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rx_done,
    output logic                        rx_irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic ovf;
    } top_t;

    top_t s_d, s_q;

    logic [NUM_LINES-1:0] pend, grant, clob;
    rx_char_t             hold_data [NUM_LINES];
    rx_char_t             pick_data;
    logic [LINE_W-1:0]    pick_idx;
    logic                 pick_any;
    logic                 push, drop, pop;
    logic                 fifo_full, fifo_empty;
    logic [CNT_W-1:0]     fifo_count;
    logic [ENTRY_W-1:0]   wdata, rdata;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        silo_line_hold hold_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (rx_stb[g]),
            .en      (line_en[g]),
            .ch      (rx_data[g*CHAR_W +: CHAR_W]),
            .ferr    (rx_ferr[g]),
            .perr    (rx_perr[g]),
            .grant   (grant[g]),
            .pend    (pend[g]),
            .data    (hold_data[g]),
            .clobber (clob[g])
        );
    end

    silo_pick #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) pick_i (
        .req   (pend),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    always_comb begin
        pick_data = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (pick_idx == LINE_W'(i)) begin
                pick_data = hold_data[i];
            end
        end
    end

    always_comb begin
        s_d   = s_q;
        push  = pick_any && !fifo_full;
        drop  = pick_any && fifo_full;
        pop   = rd_en && !fifo_empty;
        wdata = {s_q.ovf, pick_data.ferr, pick_data.perr, pick_idx, pick_data.ch};
        if (push) begin
            s_d.ovf = 1'b0;
        end
        if (drop || (|clob)) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    silo_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wdata),
        .pop   (pop),
        .rdata (rdata),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign rd_word = fifo_empty ? '0 : {1'b1, rdata};
    assign rx_done = !fifo_empty;
    assign rx_irq  = rx_done && rie;
endmodule

// File: rtl/silo_chk.sv
module silo_chk #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 64,
    parameter int CNT_W     = 7,
    parameter int WORD_W    = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 rie,
    input logic [WORD_W-1:0]    rd_word,
    input logic                 rx_done,
    input logic                 rx_irq,
    input logic [CNT_W-1:0]     count,
    input logic                 push,
    input logic                 drop,
    input logic                 ovf,
    input logic [NUM_LINES-1:0] grant
);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_drop_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> count == CNT_W'(DEPTH));

    p_loss_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);

    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_done_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done == rd_word[WORD_W-1]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rie && rd_word[WORD_W-1]));

    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_word[WORD_W-1]) |=> count <= CNT_W'(1));

    p_pop_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_word[WORD_W-1] && !push) |=> count == $past(count) - 1'b1);
endmodule

bind rx_silo silo_chk #(
    .NUM_LINES (NUM_LINES),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W),
    .WORD_W    (WORD_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rie     (rie),
    .rd_word (rd_word),
    .rx_done (rx_done),
    .rx_irq  (rx_irq),
    .count   (fifo_count),
    .push    (push),
    .drop    (drop),
    .ovf     (s_q.ovf),
    .grant   (grant)
);

// File: tb/rx_silo_tb_top.sv
module rx_silo_tb_top;
    localparam int N     = 4;
    localparam int DEPTH = 64;
    localparam int WW    = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  rx_stb = '0;
    logic [N*8-1:0] rx_data = '0;
    logic [N-1:0]  rx_ferr = '0;
    logic [N-1:0]  rx_perr = '0;
    logic [N-1:0]  line_en = '0;
    logic          rie = 1'b0;
    logic          rd_en = 1'b0;
    logic [WW-1:0] rd_word;
    logic          rx_done;
    logic          rx_irq;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    bit  m_ovf = 1'b0;
    logic [WW-1:0] exp_q[$];

    always #4 clk = ~clk;

    rx_silo dut_i (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .line_en(line_en), .rie(rie),
        .rd_en(rd_en), .rd_word(rd_word), .rx_done(rx_done), .rx_irq(rx_irq)
    );

    task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ch_of(input int l, input logic [7:0] base);
        return base + 8'(l * 37);
    endfunction

    // Model: one write of line l into the expected queue (R1 layout).
    task automatic model_push(input int l, input logic [7:0] c, input bit fe, input bit pe);
        if (exp_q.size() >= DEPTH) begin
            m_ovf = 1'b1;
        end else begin
            exp_q.push_back({1'b1, m_ovf, fe, pe, 2'(l), c});
            m_ovf = 1'b0;
        end
    endtask

    task automatic strobe(input logic [N-1:0] stb, input logic [N-1:0] en,
                          input logic [N-1:0] fe, input logic [N-1:0] pe,
                          input logic [7:0] base);
        @(negedge clk);
        rx_stb  = stb;
        line_en = en;
        rx_ferr = fe;
        rx_perr = pe;
        for (int l = 0; l < N; l++) begin
            rx_data[l*8 +: 8] = ch_of(l, base);
            if (stb[l] && en[l]) model_push(l, ch_of(l, base), fe[l], pe[l]);
        end
        @(negedge clk);
        rx_stb = '0;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_one(input string req);
        logic [WW-1:0] e;
        e = exp_q.pop_front();
        check(rd_word == e, req, rd_word, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        while (exp_q.size() != 0) read_one(req);
        // R10: empty queue reads zero, and a read leaves it empty
        check(rd_word == '0 && !rx_done, "R10 empty word", rd_word, '0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check(rd_word == '0 && !rx_done, "R10 read on empty", rd_word, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(rd_word == '0, "R11 rd_word", rd_word, '0);
        check({rx_done, rx_irq} == 2'b00, "R11 done/irq", WW'({rx_done, rx_irq}), '0);

        // R3 latency and R8/R9 outputs
        @(negedge clk);
        line_en = '1;
        rx_stb = 4'b0010;
        rx_data[15:8] = 8'h5A;
        @(negedge clk);
        rx_stb = '0;
        check(!rx_done, "R3 not visible after one edge", WW'(rx_done), '0);
        @(negedge clk);
        check(rx_done, "R3 visible after two edges", WW'(rx_done), 1);
        check(!rx_irq, "R9 irq masked when rie low", WW'(rx_irq), 0);
        rie = 1'b1;
        #1;
        check(rx_irq, "R9 irq with rie high", WW'(rx_irq), 1);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'h5A});
        check(rd_word[13] == rx_done, "R8 done equals valid", rd_word, exp_q[0]);
        drain("R1 single entry");
        check(!rx_irq, "R9 irq drops when drained", WW'(rx_irq), 0);

        // R3/R5: every strobe pattern, with framing/parity flags varied
        for (int p = 1; p < 16; p++) begin
            strobe(4'(p), 4'hF, {p[2:0], p[3]}, {p[1:0], p[3:2]}, 8'(p * 11));
            drain("R3 R5 strobe sweep");
        end
        // R4: every enable pattern with all lines strobing
        for (int e = 0; e < 16; e++) begin
            strobe(4'hF, 4'(e), 4'(e ^ 5), 4'(e ^ 10), 8'(e * 7 + 3));
            drain("R4 enable sweep");
        end

        // R2/R6: fill to exactly DEPTH, then overflow
        for (int k = 0; k < DEPTH / N; k++) strobe(4'hF, 4'hF, 4'h0, 4'h0, 8'(k * 13));
        check(rx_done && rx_irq, "R8 R9 full queue", WW'({rx_done, rx_irq}), 3);
        strobe(4'b0010, 4'hF, 4'h0, 4'h0, 8'hC3);   // dropped: queue full
        check(m_ovf, "R6 model drop expected", WW'(m_ovf), 1);
        read_one("R2 R6 head after drop");
        strobe(4'b0100, 4'hF, 4'h0, 4'h1, 8'h21);   // next entry carries overrun
        check(exp_q[exp_q.size() - 1][12], "R6 model flag", exp_q[exp_q.size() - 1], '0);
        drain("R2 R6 full drain");

        // R7: line 3 strobes twice before its first character is queued
        @(negedge clk);
        line_en = '1;
        rx_stb = 4'b1001;
        rx_data[7:0] = 8'h11;
        rx_data[31:24] = 8'h33;
        rx_ferr = '0;
        rx_perr = '0;
        @(negedge clk);
        rx_stb = 4'b1000;
        rx_data[31:24] = 8'h44;
        rx_ferr = 4'b1000;
        @(negedge clk);
        rx_stb = '0;
        rx_ferr = '0;
        repeat (5) @(negedge clk);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h11});
        exp_q.push_back({1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 8'h44});
        drain("R7 lost character");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule